// File: doc/BRIEF.md
# Battery-Backed CMOS RAM Access Gate

This block sits in front of a 256-byte battery-backed clock RAM and decides which byte-wide I/O cycles reach it. The RAM is organised as a standard 128-byte bank and an extended 128-byte bank. Each bank is reached through its own pair of ports: an index port that holds a 7-bit byte pointer, and a data port that reads or writes the byte at that pointer. The RAM is modelled inside the block.

An 8-bit configuration register controls the gate. One bit opens the extended bank's data port. Two further bits are sticky locks, one for each bank. A lock hides a fixed eight-byte window: writes to the window are dropped, and reads of it return a constant. Software can set a lock but never clear it; only the hardware reset clears the locks. The RAM array itself has no reset, so its contents survive a reset, as a battery-backed store would.

Top module: `cmos_gate`

## Requirements
- R1: After reset the configuration register reads 00h. While `io_rd_i` is low, `io_rdata_o` is 00h.
- R2: Configuration bit 2 is the extended-bank enable and reads back as written. Reserved bits 7:5 and 1:0 always read 0.
- R3: A write to I/O address 70h stores the low 7 bits of the data as the standard-bank index. A write or read at 71h accesses the standard-bank byte at that index.
- R4: When bit 2 is 1, addresses 72h and 73h act as index and data ports for the extended bank. This bank is separate storage from the standard bank.
- R5: When bit 2 is 0, a read at 73h returns FFh and a write at 73h is dropped. The extended-bank index at 72h is still written.
- R6: When bit 3 is 1, standard-bank bytes 38h-3Fh read as FFh and ignore writes. Bytes outside that window are unaffected.
- R7: When bit 4 is 1, extended-bank bytes 38h-3Fh read as FFh and ignore writes. Bytes outside that window are unaffected.
- R8: Once set, lock bits 3 and 4 stay set when 0 is written to them. Other bits written in the same cycle still take effect.
- R9: Reset clears the enable and lock bits but leaves the RAM contents unchanged.
- R10: A read at 70h or 72h returns the bank's index with bit 7 at 0. A read at any other unmapped address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 8 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration register value |

## Verification
The hardest case to reach is proving that a write to a locked byte had no effect. While the lock is set, the stored byte cannot be seen, because every read of it returns FFh. The bench therefore fills the window bytes with known values and then sets the locks. It next attempts writes to the window, pulses the hardware reset, re-enables the extended bank and reads the bytes back. Only the values from before the lock should be present. This sequence also covers sticky-lock clearing by reset and RAM retention across reset in one pass.

// File: rtl/cmos_gate_pkg.sv
package cmos_gate_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BANK_AW = 7;
  localparam int unsigned NBANK   = 2;
  localparam int unsigned CFG_EN  = 2;
  localparam int unsigned CFG_LKL = 3;
  localparam int unsigned CFG_LKH = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_IDX,
    SEL_DAT
  } port_sel_e;
endpackage

// File: rtl/cmos_cfg_reg.sv
module cmos_cfg_reg
  import cmos_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              up_en_o,
  output logic [NBANK-1:0]  lock_o
);
  logic             en_q;
  logic [NBANK-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= '0;
    end else if (wr_i) begin
      en_q   <= wdata_i[CFG_EN];
      // locks only ever set from software
      lock_q <= lock_q | {wdata_i[CFG_LKH], wdata_i[CFG_LKL]};
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[CFG_EN]  = en_q;
    rdata_o[CFG_LKL] = lock_q[0];
    rdata_o[CFG_LKH] = lock_q[1];
  end

  assign up_en_o = en_q;
  assign lock_o  = lock_q;

  a_r8_lock_lo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q[0] |=> lock_q[0]);
  a_r8_lock_hi_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q[1] |=> lock_q[1]);
  a_r2_en_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (up_en_o == $past(wdata_i[CFG_EN])));
endmodule

// File: rtl/cmos_port_dec.sv
module cmos_port_dec
  import cmos_gate_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LO_IDX_ADDR = 8'h70,
  parameter logic [BYTE_W-1:0] HI_IDX_ADDR = 8'h72
) (
  input  logic [BYTE_W-1:0] addr_i,
  output port_sel_e         sel_o [NBANK]
);
  localparam logic [BYTE_W-1:0] BASE [NBANK] = '{LO_IDX_ADDR, HI_IDX_ADDR};

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    always_comb begin
      if (addr_i == BASE[b])               sel_o[b] = SEL_IDX;
      else if (addr_i == BASE[b] + 8'd1)   sel_o[b] = SEL_DAT;
      else                                 sel_o[b] = SEL_NONE;
    end
  end
endmodule

// File: rtl/cmos_ram_bank.sv
module cmos_ram_bank
  import cmos_gate_pkg::*;
#(
  parameter logic [BANK_AW-1:0] WIN_LO = 7'h38,
  parameter logic [BANK_AW-1:0] WIN_HI = 7'h3F
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic               lock_i,
  input  logic [BANK_AW-1:0] idx_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0]  rdata_o,
  output logic               blocked_o
);
  localparam int unsigned DEPTH = 1 << BANK_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  assign blocked_o = lock_i && (idx_i >= WIN_LO) && (idx_i <= WIN_HI);

  // no reset: contents are battery backed
  always_ff @(posedge clk_i) begin
    if (we_i && !blocked_o) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = blocked_o ? '1 : mem[idx_i];
endmodule

// File: rtl/cmos_gate.sv
module cmos_gate
  import cmos_gate_pkg::*;
#(
  parameter logic [BYTE_W-1:0]  LO_IDX_ADDR = 8'h70,
  parameter logic [BYTE_W-1:0]  HI_IDX_ADDR = 8'h72,
  parameter logic [BANK_AW-1:0] WIN_LO      = 7'h38,
  parameter logic [BANK_AW-1:0] WIN_HI      = 7'h3F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [BYTE_W-1:0] io_wdata_i,
  output logic [BYTE_W-1:0] io_rdata_o,
  input  logic              cfg_wr_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic [BYTE_W-1:0] cfg_rdata_o
);
  logic               up_en;
  logic [NBANK-1:0]   lock;
  port_sel_e          sel [NBANK];
  logic [BANK_AW-1:0] idx_q   [NBANK];
  logic [BYTE_W-1:0]  bk_rd   [NBANK];
  logic [NBANK-1:0]   bk_we;
  logic [NBANK-1:0]   bk_blk;
  logic [NBANK-1:0]   bk_open;

  cmos_cfg_reg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .up_en_o (up_en),
    .lock_o  (lock)
  );

  cmos_port_dec #(
    .LO_IDX_ADDR (LO_IDX_ADDR),
    .HI_IDX_ADDR (HI_IDX_ADDR)
  ) i_dec (
    .addr_i (io_addr_i),
    .sel_o  (sel)
  );

  assign bk_open = {up_en, 1'b1};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           idx_q[b] <= '0;
      else if (io_wr_i && sel[b] == SEL_IDX) idx_q[b] <= io_wdata_i[BANK_AW-1:0];
    end

    assign bk_we[b] = io_wr_i && (sel[b] == SEL_DAT) && bk_open[b];

    cmos_ram_bank #(
      .WIN_LO (WIN_LO),
      .WIN_HI (WIN_HI)
    ) i_bank (
      .clk_i     (clk_i),
      .we_i      (bk_we[b]),
      .lock_i    (lock[b]),
      .idx_i     (idx_q[b]),
      .wdata_i   (io_wdata_i),
      .rdata_o   (bk_rd[b]),
      .blocked_o (bk_blk[b])
    );
  end

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      for (int b = 0; b < NBANK; b++) begin
        if (sel[b] == SEL_IDX)      io_rdata_o = {{(BYTE_W-BANK_AW){1'b0}}, idx_q[b]};
        else if (sel[b] == SEL_DAT) io_rdata_o = bk_open[b] ? bk_rd[b] : '1;
      end
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == '0);
  a_r5_hi_off_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[CFG_EN] |-> !bk_we[1]);
  a_r5_hi_off_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !cfg_rdata_o[CFG_EN] && io_addr_i == HI_IDX_ADDR + 8'd1) |-> io_rdata_o == '1);
  a_r6_lo_window_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && cfg_rdata_o[CFG_LKL] && io_addr_i == LO_IDX_ADDR + 8'd1 &&
     idx_q[0] >= WIN_LO && idx_q[0] <= WIN_HI) |-> io_rdata_o == '1);
  a_r7_hi_window_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[CFG_LKH] && idx_q[1] >= WIN_LO && idx_q[1] <= WIN_HI) |-> bk_blk[1]);
  a_r10_index_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == LO_IDX_ADDR) |-> io_rdata_o[BYTE_W-1] == 1'b0);
endmodule

// File: tb/test_cmos_gate.sv
module test_cmos_gate;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cmos_gate i_cmos_gate (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .io_addr_i   (io_addr),
    .io_wr_i     (io_wr),
    .io_rd_i     (io_rd),
    .io_wdata_i  (io_wdata),
    .io_rdata_o  (io_rdata),
    .cfg_wr_i    (cfg_wr),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic bank_wr(input bit hi, input logic [6:0] i, input logic [7:0] d);
    io_write(hi ? 8'h72 : 8'h70, {1'b0, i});
    io_write(hi ? 8'h73 : 8'h71, d);
  endtask

  task automatic bank_rd(input bit hi, input logic [6:0] i, output logic [7:0] d);
    io_write(hi ? 8'h72 : 8'h70, {1'b0, i});
    io_read(hi ? 8'h73 : 8'h71, d);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cfg_rdata, 8'h00, "R1 cfg after reset");
    check(io_rdata, 8'h00, "R1 idle read data");
  endtask

  task automatic t_lower;
    logic [7:0] d;
    io_write(8'h70, 8'h85);
    io_read(8'h70, d);
    check(d, 8'h05, "R10 index keeps low 7 bits");
    io_write(8'h71, 8'hA5);
    io_read(8'h71, d);
    check(d, 8'hA5, "R3 lower data readback");
    bank_wr(1'b0, 7'h10, 8'h3C);
    bank_rd(1'b0, 7'h05, d);
    check(d, 8'hA5, "R3 lower byte kept");
    io_read(8'h74, d);
    check(d, 8'h00, "R10 unmapped read");
  endtask

  task automatic t_upper;
    logic [7:0] d;
    cfg_write(8'hE7);
    @(negedge clk);
    check(cfg_rdata, 8'h04, "R2 enable set, reserved zero");
    bank_wr(1'b1, 7'h05, 8'h5A);
    bank_rd(1'b1, 7'h05, d);
    check(d, 8'h5A, "R4 upper data readback");
    bank_rd(1'b0, 7'h05, d);
    check(d, 8'hA5, "R4 lower separate from upper");
    bank_wr(1'b1, 7'h06, 8'h77);
  endtask

  task automatic t_upper_off;
    logic [7:0] d;
    cfg_write(8'h00);
    @(negedge clk);
    check(cfg_rdata, 8'h00, "R2 enable cleared");
    bank_wr(1'b1, 7'h06, 8'h11);
    io_read(8'h73, d);
    check(d, 8'hFF, "R5 disabled upper reads FF");
    io_read(8'h72, d);
    check(d, 8'h06, "R5 upper index still written");
    cfg_write(8'h04);
    io_read(8'h73, d);
    check(d, 8'h77, "R5 disabled write dropped");
  endtask

  task automatic t_locks;
    logic [7:0] d;
    bank_wr(1'b0, 7'h38, 8'h12);
    bank_wr(1'b0, 7'h3F, 8'h34);
    bank_wr(1'b0, 7'h37, 8'h56);
    bank_wr(1'b0, 7'h40, 8'h78);
    bank_wr(1'b1, 7'h3A, 8'h21);
    bank_wr(1'b1, 7'h41, 8'h43);
    cfg_write(8'h0C);
    bank_rd(1'b0, 7'h38, d);  check(d, 8'hFF, "R6 lock low edge");
    bank_rd(1'b0, 7'h3F, d);  check(d, 8'hFF, "R6 lock high edge");
    bank_rd(1'b0, 7'h37, d);  check(d, 8'h56, "R6 below window");
    bank_rd(1'b0, 7'h40, d);  check(d, 8'h78, "R6 above window");
    bank_wr(1'b0, 7'h38, 8'h99);
    bank_wr(1'b0, 7'h37, 8'h9A);
    bank_rd(1'b0, 7'h37, d);  check(d, 8'h9A, "R6 write outside window");
    bank_rd(1'b1, 7'h3A, d);  check(d, 8'h21, "R7 upper open before its lock");
    cfg_write(8'h14);
    @(negedge clk);
    check(cfg_rdata, 8'h1C, "R8 lower lock kept, upper lock set");
    bank_rd(1'b1, 7'h3A, d);  check(d, 8'hFF, "R7 upper window reads FF");
    bank_wr(1'b1, 7'h3A, 8'h22);
    bank_rd(1'b1, 7'h41, d);  check(d, 8'h43, "R7 upper outside window");
    cfg_write(8'h00);
    @(negedge clk);
    check(cfg_rdata, 8'h18, "R8 zero write keeps locks, clears enable");
  endtask

  task automatic t_reset_keep;
    logic [7:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata, 8'h00, "R9 reset clears locks and enable");
    cfg_write(8'h04);
    bank_rd(1'b0, 7'h38, d);  check(d, 8'h12, "R6 locked write had no effect");
    bank_rd(1'b0, 7'h3F, d);  check(d, 8'h34, "R9 RAM kept over reset");
    bank_rd(1'b1, 7'h3A, d);  check(d, 8'h21, "R7 locked write had no effect");
    bank_rd(1'b0, 7'h05, d);  check(d, 8'hA5, "R9 lower byte kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lower();
    t_upper();
    t_upper_off();
    t_locks();
    t_reset_keep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule